// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This block turns one vector operation into a stream of element operations for an execution unit. After a start pulse it takes a snapshot of the vector length, the vector or scalar flag of each operand, the base register numbers and two mode bits. It then issues one element per accepted handshake. For each element it gives the destination and two source register indices.

For a vector operand the register index is its base plus the element index, modulo the register-index width. For a scalar operand the index stays at its base. The element order rises through the vector by default. A reverse bit makes it fall instead.

A scalar destination normally stops the loop after one element. With the map-reduce bit set, the block keeps issuing every element into the same fixed destination, which acts as an accumulator. When no scalar source equals the destination, there is no accumulator. In that case every element but the final one would be overwritten, so only the final element is issued. The order of issue is always strict and deterministic, so that floating-point reductions can be reproduced.

Top module: `vec_issue_seq`

## Requirements
- R1: After reset, valid_o and done_o are low.
- R2: With reverse_i low and a vector destination, elements 0 to VL-1 are each issued once in rising order, and elem_o gives the element index. A vector operand's index is (base + element) mod 2^REG_W. A scalar operand's index equals its base.
- R3: With reverse_i high, the element index runs from VL-1 down to 0. This holds for a vector destination and for a map-reduce scalar destination.
- R4: With a scalar destination and mapred_i low, exactly one element is issued. It is element 0, or element VL-1 when reverse_i is high.
- R5: With a scalar destination, mapred_i high, and a scalar source whose base equals the destination base, all VL elements are issued and rt_o stays at the destination base.
- R6: With a scalar destination, mapred_i high, and no scalar source equal to the destination base, exactly one element is issued. It is the last one in issue order: VL-1 going forward, 0 in reverse.
- R7: While valid_o is high and ready_i is low, valid_o and all index outputs hold their values into the next cycle.
- R8: A VL of 0 issues no element, and done_o is high in the cycle after start.
- R9: done_o is high for exactly one cycle, the one after the last element is accepted, and is never high together with valid_o. The next cycle is idle.
- R10: A start pulse while an operation is in progress is ignored. The running sequence, including its operands and order, is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| vl_i | input | VLW | Vector length, 0 to VL_MAX |
| rt_vec_i | input | 1 | Destination is a vector |
| ra_vec_i | input | 1 | First source is a vector |
| rb_vec_i | input | 1 | Second source is a vector |
| mapred_i | input | 1 | Keep issuing into a scalar destination |
| reverse_i | input | 1 | Run element index downward |
| rt_base_i | input | REG_W | Destination base register |
| ra_base_i | input | REG_W | First source base register |
| rb_base_i | input | REG_W | Second source base register |
| ready_i | input | 1 | Execution unit accepts the element |
| valid_o | output | 1 | Element operation on the outputs |
| elem_o | output | VLW | Element index |
| rt_o | output | REG_W | Destination register index |
| ra_o | output | REG_W | First source register index |
| rb_o | output | REG_W | Second source register index |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench pairs a scalar destination with the map-reduce bit, once with an accumulator source and once without. A design that mixes up these cases would issue a single element where every element is needed, or issue every element where only the last one is. It runs both orders with irregular ready stalls. A wrong design would skip or repeat an element across a stall, or change the indices while the element waits. It also tries a zero vector length, a register index that wraps past the top of its range, and a start pulse in the middle of a run. Bad handling of these would hang without done, produce a wrong register after the wrap, or restart with the new length.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} vis_state_e;
endpackage

// File: rtl/vis_plan.sv
// Start-time planning: first element index and count of remaining issues.
module vis_plan #(
  parameter int VLW      = 4,
  parameter bit ELIDE_EN = 1'b1
) (
  input  logic [VLW-1:0] vl_i,
  input  logic           rt_vec_i,
  input  logic           ra_vec_i,
  input  logic           rb_vec_i,
  input  logic           ra_eq_rt_i,
  input  logic           rb_eq_rt_i,
  input  logic           mapred_i,
  input  logic           reverse_i,
  output logic           empty_o,
  output logic [VLW-1:0] first_o,
  output logic [VLW-1:0] left_o
);
  logic single_first, single_last, accum;
  logic [VLW-1:0] vl_m1;

  assign vl_m1        = vl_i - 1'b1;
  assign empty_o      = (vl_i == '0);
  assign accum        = (!ra_vec_i && ra_eq_rt_i) || (!rb_vec_i && rb_eq_rt_i);
  assign single_first = !rt_vec_i && !mapred_i;
  assign single_last  = ELIDE_EN && !rt_vec_i && mapred_i && !accum;

  always_comb begin
    if (single_last) first_o = reverse_i ? '0 : vl_m1;
    else             first_o = reverse_i ? vl_m1 : '0;
    left_o = (single_first || single_last) ? '0 : vl_m1;
  end
endmodule

// File: rtl/vis_ctrl.sv
module vis_ctrl
  import vis_pkg::*;
#(
  parameter int VLW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           accept_i,
  input  logic           empty_i,
  input  logic [VLW-1:0] first_i,
  input  logic [VLW-1:0] left_i,
  input  logic           rev_q_i,
  input  logic           ready_i,
  output logic           idle_o,
  output logic           valid_o,
  output logic           done_o,
  output logic [VLW-1:0] idx_o
);
  vis_state_e st_q;
  logic [VLW-1:0] idx_q, left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      left_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_i) begin
          st_q   <= empty_i ? ST_DONE : ST_RUN;
          idx_q  <= first_i;
          left_q <= left_i;
        end
        ST_RUN: if (ready_i) begin
          if (left_q == '0) st_q <= ST_DONE;
          else begin
            idx_q  <= rev_q_i ? idx_q - 1'b1 : idx_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == ST_IDLE);
  assign valid_o = (st_q == ST_RUN);
  assign done_o  = (st_q == ST_DONE);
  assign idx_o   = idx_q;
endmodule

// File: rtl/vis_opnd_map.sv
module vis_opnd_map #(
  parameter int REG_W = 7,
  parameter int VLW   = 4
) (
  input  logic [REG_W-1:0] base_i,
  input  logic             is_vec_i,
  input  logic [VLW-1:0]   idx_i,
  output logic [REG_W-1:0] reg_o
);
  assign reg_o = is_vec_i ? base_i + REG_W'(idx_i) : base_i;
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq #(
  parameter int REG_W    = 7,
  parameter int VL_MAX   = 8,
  parameter bit ELIDE_EN = 1'b1,
  localparam int VLW     = $clog2(VL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic             rt_vec_i,
  input  logic             ra_vec_i,
  input  logic             rb_vec_i,
  input  logic             mapred_i,
  input  logic             reverse_i,
  input  logic [REG_W-1:0] rt_base_i,
  input  logic [REG_W-1:0] ra_base_i,
  input  logic [REG_W-1:0] rb_base_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [VLW-1:0]   elem_o,
  output logic [REG_W-1:0] rt_o,
  output logic [REG_W-1:0] ra_o,
  output logic [REG_W-1:0] rb_o,
  output logic             done_o
);
  localparam int NOPND = 3;

  logic                        idle, accept, empty;
  logic [VLW-1:0]              first, left, idx;
  logic [NOPND-1:0][REG_W-1:0] base_q, reg_w;
  logic [NOPND-1:0]            vec_q;
  logic                        rev_q;

  assign accept = start_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vec_q  <= '0;
      rev_q  <= 1'b0;
    end else if (accept) begin
      base_q <= {rb_base_i, ra_base_i, rt_base_i};
      vec_q  <= {rb_vec_i, ra_vec_i, rt_vec_i};
      rev_q  <= reverse_i;
    end
  end

  vis_plan #(.VLW(VLW), .ELIDE_EN(ELIDE_EN)) plan_i (
    .vl_i(vl_i), .rt_vec_i(rt_vec_i), .ra_vec_i(ra_vec_i), .rb_vec_i(rb_vec_i),
    .ra_eq_rt_i(ra_base_i == rt_base_i), .rb_eq_rt_i(rb_base_i == rt_base_i),
    .mapred_i(mapred_i), .reverse_i(reverse_i),
    .empty_o(empty), .first_o(first), .left_o(left)
  );

  vis_ctrl #(.VLW(VLW)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .empty_i(empty),
    .first_i(first), .left_i(left), .rev_q_i(rev_q), .ready_i(ready_i),
    .idle_o(idle), .valid_o(valid_o), .done_o(done_o), .idx_o(idx)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    vis_opnd_map #(.REG_W(REG_W), .VLW(VLW)) map_i (
      .base_i(base_q[g]), .is_vec_i(vec_q[g]), .idx_i(idx), .reg_o(reg_w[g])
    );
  end

  assign elem_o = idx;
  assign rt_o   = reg_w[0];
  assign ra_o   = reg_w[1];
  assign rb_o   = reg_w[2];
endmodule

// File: rtl/vis_sva.sv
module vis_sva #(
  parameter int REG_W = 7,
  parameter int VLW   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic             ready_i,
  input logic             done_o,
  input logic [VLW-1:0]   elem_o,
  input logic [REG_W-1:0] rt_o,
  input logic [REG_W-1:0] ra_o,
  input logic [REG_W-1:0] rb_o,
  input logic             rt_vec_q,
  input logic [REG_W-1:0] rt_base_q,
  input logic             rev_q
);
  assert_hold_on_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(elem_o) && $stable(rt_o) && $stable(ra_o) && $stable(rb_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !valid_o);

  assert_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));

  assert_scalar_dest_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rt_vec_q |-> rt_o == rt_base_q);

  assert_fwd_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o && ready_i) && !rev_q |-> elem_o == VLW'($past(elem_o) + 1'b1));

  assert_rev_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o && ready_i) && rev_q |-> elem_o == VLW'($past(elem_o) - 1'b1));
endmodule

bind vec_issue_seq vis_sva #(.REG_W(REG_W), .VLW(VLW)) sva_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_o(valid_o), .ready_i(ready_i),
  .done_o(done_o), .elem_o(elem_o), .rt_o(rt_o), .ra_o(ra_o), .rb_o(rb_o),
  .rt_vec_q(vec_q[0]), .rt_base_q(base_q[0]), .rev_q(rev_q)
);

// File: tb/vec_issue_seq_tb_top.sv
`timescale 1ns/1ps
module vec_issue_seq_tb_top;
  localparam int REG_W = 7;
  localparam int VLW   = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, rt_vec_i = 0, ra_vec_i = 0, rb_vec_i = 0, mapred_i = 0, reverse_i = 0;
  logic ready_i = 0;
  logic [VLW-1:0] vl_i = '0;
  logic [REG_W-1:0] rt_base_i = '0, ra_base_i = '0, rb_base_i = '0;
  logic valid_o, done_o;
  logic [VLW-1:0] elem_o;
  logic [REG_W-1:0] rt_o, ra_o, rb_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  vec_issue_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vl_i(vl_i),
    .rt_vec_i(rt_vec_i), .ra_vec_i(ra_vec_i), .rb_vec_i(rb_vec_i),
    .mapred_i(mapred_i), .reverse_i(reverse_i),
    .rt_base_i(rt_base_i), .ra_base_i(ra_base_i), .rb_base_i(rb_base_i),
    .ready_i(ready_i), .valid_o(valid_o), .elem_o(elem_o),
    .rt_o(rt_o), .ra_o(ra_o), .rb_o(rb_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int reg_of(input bit is_vec, input int base, input int e);
    return is_vec ? ((base + e) % (1 << REG_W)) : base;
  endfunction

  task automatic run_op(input int vl, input bit rtv, input bit rav, input bit rbv,
                        input bit mr, input bit rv, input int rtb, input int rab,
                        input int rbb, input bit stall, input bit poke, input string req);
    bit single_first, single_last, accum, seen, prev_stall;
    int n, k, last_acc, e;
    int p_elem, p_rt, p_ra, p_rb;
    accum        = (!rav && rab == rtb) || (!rbv && rbb == rtb);
    single_first = !rtv && !mr;
    single_last  = !rtv && mr && !accum;
    n = (vl == 0) ? 0 : ((single_first || single_last) ? 1 : vl);
    k = 0; last_acc = 0; seen = 0; prev_stall = 0;
    p_elem = 0; p_rt = 0; p_ra = 0; p_rb = 0;
    @(negedge clk_i);
    start_i = 1; vl_i = VLW'(vl); rt_vec_i = rtv; ra_vec_i = rav; rb_vec_i = rbv;
    mapred_i = mr; reverse_i = rv;
    rt_base_i = REG_W'(rtb); ra_base_i = REG_W'(rab); rb_base_i = REG_W'(rbb);
    for (int cyc = 1; cyc < 60; cyc++) begin
      @(negedge clk_i);
      start_i = 0;
      if (poke && cyc == 2) begin   // R10: restart attempt with other settings
        start_i = 1; vl_i = 4'd1; reverse_i = !rv; rt_base_i = REG_W'(rtb + 3);
      end
      ready_i = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (prev_stall) begin       // R7
        chk(valid_o == 1'b1, "R7", "valid held", int'(valid_o), 1);
        chk(int'(elem_o) == p_elem && int'(rt_o) == p_rt && int'(ra_o) == p_ra && int'(rb_o) == p_rb,
            "R7", "indices held (elem)", int'(elem_o), p_elem);
      end
      if (valid_o) begin
        if (ready_i) begin
          if (k < n) begin
            if (single_last)       e = rv ? 0 : vl - 1;
            else if (single_first) e = rv ? vl - 1 : 0;
            else                   e = rv ? vl - 1 - k : k;
            chk(int'(elem_o) == e, req, "elem", int'(elem_o), e);
            chk(int'(rt_o) == reg_of(rtv, rtb, e), req, "rt", int'(rt_o), reg_of(rtv, rtb, e));
            chk(int'(ra_o) == reg_of(rav, rab, e), req, "ra", int'(ra_o), reg_of(rav, rab, e));
            chk(int'(rb_o) == reg_of(rbv, rbb, e), req, "rb", int'(rb_o), reg_of(rbv, rbb, e));
          end else chk(1'b0, req, "extra element", k + 1, n);
          k++;
          last_acc = cyc;
        end
        prev_stall = !ready_i;
        p_elem = int'(elem_o); p_rt = int'(rt_o); p_ra = int'(ra_o); p_rb = int'(rb_o);
      end else prev_stall = 0;
      if (done_o) begin
        chk(!valid_o, "R9", "valid with done", int'(valid_o), 0);
        chk(k == n, req, "issued count", k, n);
        chk(cyc == last_acc + 1, (vl == 0) ? "R8" : "R9", "done cycle", cyc, last_acc + 1);
        seen = 1;
        break;
      end
    end
    if (!seen) chk(1'b0, req, "done never seen", 0, 1);
    @(negedge clk_i);
    #1;
    chk(!valid_o && !done_o, "R9", "idle after done", int'({valid_o, done_o}), 0);
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!valid_o && !done_o, "R1", "reset outputs", int'({valid_o, done_o}), 0);
    rst_ni = 1;
    @(negedge clk_i);
    #1;
    chk(!valid_o && !done_o, "R1", "idle after reset", int'({valid_o, done_o}), 0);
    // vl, rtv, rav, rbv, mr, rv, rtb, rab, rbb, stall, poke, req
    run_op(5, 1, 1, 1, 0, 0, 10, 20, 30, 0, 0, "R2");
    run_op(4, 1, 0, 1, 0, 0, 50, 60, 70, 1, 0, "R2");
    run_op(8, 1, 1, 0, 0, 0, 124, 126, 9, 0, 0, "R2");   // index wrap
    run_op(4, 1, 1, 0, 0, 1, 10, 20, 30, 0, 0, "R3");
    run_op(7, 1, 1, 1, 0, 1, 40, 50, 60, 1, 0, "R3");
    run_op(6, 0, 1, 1, 0, 0, 8, 16, 24, 0, 0, "R4");
    run_op(6, 0, 1, 1, 0, 1, 8, 16, 24, 0, 0, "R4");
    run_op(4, 0, 0, 1, 1, 0, 8, 8, 40, 1, 0, "R5");
    run_op(5, 0, 1, 0, 1, 1, 8, 32, 8, 0, 0, "R5");
    run_op(4, 0, 1, 1, 1, 0, 8, 16, 24, 0, 0, "R6");
    run_op(4, 0, 1, 1, 1, 1, 8, 16, 24, 1, 0, "R6");
    run_op(0, 1, 1, 1, 0, 0, 10, 20, 30, 0, 0, "R8");
    run_op(5, 1, 1, 1, 0, 0, 10, 20, 30, 1, 1, "R10");
    run_op(1, 1, 1, 1, 0, 1, 3, 4, 5, 1, 0, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule